// File: doc/BRIEF.md
# Clocked Burst Read Address Sequencer

This block sits in front of a word-wide memory array and turns a single burst request into a stream of word addresses, one per clock, together with a per-cycle data-valid flag and a wait indication. The array itself is modelled as a combinational lookup, so every valid beat also carries the array word for its address.

The burst mode lives in a 16-bit configuration register. Software loads it with two bus writes: first a setup code on the command lines, then a confirm code, with the new register value carried on the low 16 address lines. A pulse on `start_i` latches the start address and the current mode. The block then waits out the programmed latency and delivers beats, either within a 4- or 8-word wrap window (sequential or interleaved order) or as an open-ended linear stream that runs until `stop_i`. An open-ended burst that begins off a 4-word boundary inserts one wait cycle the first time it crosses such a boundary. The ready output is meaningful only for these open-ended bursts.

Top module: `burst_read_seq`

## Requirements
- R1: When a write with command code 0xC3 is followed by a second write (the next cycle with `wr_i` high) carrying code 0x3C, `cfg_o` takes `addr_i[15:0]` on that second write, with `cfg_o[i]` from `addr_i[i]`, and is visible from the next cycle.
- R2: If the write that follows a 0xC3 setup carries any code other than 0x3C, `cfg_o` keeps its value; a lone 0x3C write without a preceding setup also leaves `cfg_o` unchanged.
- R3: After reset `cfg_o` is 0x8000, no burst is running, `valid_o` is low and `ready_o` is high.
- R4: While `cfg_o[15]` is 1 (asynchronous read mode), `start_i` is ignored: no beat ever becomes valid.
- R5: With X = `cfg_o[13:11]` (values 0 and 1 behave as 2) and the start pulse in cycle 0, the first beat is valid in cycle X and later beats follow on consecutive cycles except for an R10 wait.
- R6: `cfg_o[2:0]` sets the length: 001 gives 4 beats, 010 gives 8 beats, every other code gives an open-ended burst; a fixed burst drops `valid_o` after its last beat.
- R7: With `cfg_o[7]` = 0 a fixed burst of length L from start address s yields beat k at address (s with its low log2(L) bits replaced by (s+k) mod L).
- R8: With `cfg_o[7]` = 1 a fixed burst yields beat k at (s with its low log2(L) bits replaced by (s XOR k) mod L).
- R9: An open-ended burst yields beat k at address s+k modulo the array size, never wrapping within a window; `cfg_o[7]` has no effect on it.
- R10: An open-ended burst whose start has `s[1:0]` nonzero holds exactly one cycle with `valid_o` and `ready_o` low between the beat at an address ending in 3 and the next beat, only at the first such crossing.
- R11: During an open-ended burst `ready_o` is low in every cycle without a valid beat (latency and wait) and high with one; at all other times, including fixed bursts, `ready_o` is high.
- R12: `stop_i` ends any burst so that the next cycle shows `valid_o` low; `start_i` during a running burst abandons it and starts the new one.
- R13: On every valid beat `data_o` equals `addr_o[15:0]` XOR 0x5A3C, the modelled array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe for the command path |
| wr_data_i | input | 8 | Command code on a bus write |
| addr_i | input | 21 | Word address: burst start, or configuration value on bits 15:0 |
| start_i | input | 1 | Address-latch pulse that begins a burst |
| stop_i | input | 1 | Terminates the current burst |
| cfg_o | output | 16 | Current configuration register |
| addr_o | output | 21 | Array word address of the current beat |
| data_o | output | 16 | Array word at `addr_o` |
| valid_o | output | 1 | Beat on `addr_o`/`data_o` is valid this cycle |
| ready_o | output | 1 | Low while an open-ended burst has no valid data |

## Verification
The hardest case to reach is the single wait cycle of an open-ended burst: it needs asynchronous mode cleared, an open-ended length code, a start offset of 1, 2 or 3 within a 4-word window, and a run long enough to cross two boundaries so that the absence of a second wait is seen. Directed runs cover all three offsets, an aligned start and a start near the top of the array where the address wraps to zero, and the random phase draws offsets and length codes so the crossing falls at varied latencies. A restart issued mid-burst and the stop after each run confirm that no state leaks from one burst into the next.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int CFG_W       = 16;
  localparam int CFG_ASYNC   = 15;
  localparam int CFG_XLAT_LO = 11;
  localparam int CFG_ILV     = 7;

  typedef enum logic [1:0] {LEN_4, LEN_8, LEN_CONT} len_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_GAP} st_e;

  function automatic len_e decode_len(logic [2:0] code);
    case (code)
      3'b001:  return LEN_4;
      3'b010:  return LEN_8;
      default: return LEN_CONT;
    endcase
  endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg #(
  parameter int            CMD_W   = 8,
  parameter logic [CMD_W-1:0] SETUP   = 8'hC3,
  parameter logic [CMD_W-1:0] CONFIRM = 8'h3C,
  parameter logic [15:0]   RST_VAL = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic [15:0]      val_i,
  output logic [15:0]      cfg_o,
  output logic             armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= RST_VAL;
      armed_o <= 1'b0;
    end else if (wr_i) begin
      if (armed_o) begin
        armed_o <= 1'b0;
        if (wr_data_i == CONFIRM) cfg_o <= val_i;
      end else begin
        armed_o <= (wr_data_i == SETUP);
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] beat_i,
  input  len_e              len_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mask, low;

  always_comb begin
    mask = (len_i == LEN_8) ? ADDR_W'(7) : ADDR_W'(3);
    low  = ilv_i ? (base_i ^ beat_i) : (base_i + beat_i);
    if (len_i == LEN_CONT) addr_o = base_i + beat_i;
    else                   addr_o = (base_i & ~mask) | (low & mask);
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output st_e               state_o,
  output logic [ADDR_W-1:0] beat_o,
  output logic [ADDR_W-1:0] base_o,
  output len_e              len_o,
  output logic              ilv_o
);
  logic [2:0] xl, xl_eff, cnt;
  logic       gap_done;
  logic       last_fixed;

  assign xl         = cfg_i[CFG_XLAT_LO +: 3];
  assign xl_eff     = (xl < 3'd2) ? 3'd2 : xl;
  assign last_fixed = (len_o == LEN_8) ? (beat_o == ADDR_W'(7)) : (beat_o == ADDR_W'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= ST_IDLE;
      cnt      <= '0;
      beat_o   <= '0;
      base_o   <= '0;
      len_o    <= LEN_4;
      ilv_o    <= 1'b0;
      gap_done <= 1'b1;
    end else if (start_i && !cfg_i[CFG_ASYNC]) begin
      state_o  <= ST_LAT;
      cnt      <= xl_eff - 3'd1;
      beat_o   <= '0;
      base_o   <= start_addr_i;
      len_o    <= decode_len(cfg_i[2:0]);
      ilv_o    <= cfg_i[CFG_ILV];
      gap_done <= (start_addr_i[1:0] == 2'b00);
    end else if (stop_i) begin
      state_o <= ST_IDLE;
    end else begin
      case (state_o)
        ST_LAT: begin
          if (cnt == 3'd1) state_o <= ST_DATA;
          else             cnt <= cnt - 3'd1;
        end
        ST_DATA: begin
          if (len_o != LEN_CONT && last_fixed) begin
            state_o <= ST_IDLE;
          end else begin
            beat_o <= beat_o + 1'b1;
            // one wait at the first window crossing of an unaligned stream
            if (len_o == LEN_CONT && !gap_done && cur_addr_i[1:0] == 2'b11) begin
              state_o  <= ST_GAP;
              gap_done <= 1'b1;
            end
          end
        end
        ST_GAP:  state_o <= ST_DATA;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_array_model.sv
module burst_array_model #(
  parameter int              ADDR_W = 21,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'h5A3C
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = DATA_W'(addr_i) ^ SEED;
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int              ADDR_W  = 21,
  parameter int              DATA_W  = 16,
  parameter int              CMD_W   = 8,
  parameter logic [CMD_W-1:0] SETUP   = 8'hC3,
  parameter logic [CMD_W-1:0] CONFIRM = 8'h3C,
  parameter logic [DATA_W-1:0] SEED   = 16'h5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ready_o
);
  st_e               state;
  logic [ADDR_W-1:0] beat, base;
  len_e              len;
  logic              ilv, cfg_armed;
  logic              burst_active, burst_cont, burst_gap;

  burst_cfg_reg #(.CMD_W(CMD_W), .SETUP(SETUP), .CONFIRM(CONFIRM), .RST_VAL(16'h8000)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .val_i(addr_i[CFG_W-1:0]), .cfg_o, .armed_o(cfg_armed)
  );

  burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .cfg_i(cfg_o), .start_i, .stop_i,
    .start_addr_i(addr_i), .cur_addr_i(addr_o),
    .state_o(state), .beat_o(beat), .base_o(base), .len_o(len), .ilv_o(ilv)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .base_i(base), .beat_i(beat), .len_i(len), .ilv_i(ilv), .addr_o
  );

  burst_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_arr (
    .addr_i(addr_o), .data_o
  );

  assign burst_active = (state != ST_IDLE);
  assign burst_cont   = burst_active && (len == LEN_CONT);
  assign burst_gap    = (state == ST_GAP);
  assign valid_o      = (state == ST_DATA);
  assign ready_o      = !(burst_cont && !valid_o);
endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int              ADDR_W  = 21,
  parameter int              CMD_W   = 8,
  parameter logic [CMD_W-1:0] CONFIRM = 8'h3C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [CMD_W-1:0]  wr_data_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              start_i,
  input logic [15:0]       cfg_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              ready_o,
  input logic              cfg_armed,
  input logic              burst_active,
  input logic              burst_cont,
  input logic              burst_gap
);
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cfg_armed && wr_data_i == CONFIRM) |=> (cfg_o == $past(addr_i[15:0]))); // R1

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && cfg_armed && wr_data_i == CONFIRM) |=> $stable(cfg_o)); // R2

  AST_ASYNC_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_o[15] && !burst_active) |=> !burst_active); // R4

  AST_FIXED_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !burst_cont) |->
      (addr_o[ADDR_W-1:3] == $past(addr_o[ADDR_W-1:3]))); // R7

  AST_CONT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && burst_cont) |-> (addr_o == $past(addr_o) + 1'b1)); // R9

  AST_GAP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_gap |-> (!ready_o && !valid_o)); // R10

  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_active |-> ready_o); // R11
endmodule

bind burst_read_seq burst_read_seq_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .CONFIRM(CONFIRM)) u_chk (
  .clk_i, .rst_ni, .wr_i, .wr_data_i, .addr_i, .start_i, .cfg_o, .addr_o,
  .valid_o, .ready_o, .cfg_armed, .burst_active, .burst_cont, .burst_gap
);

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;
  localparam int AW = 21;
  localparam logic [7:0]  SETUP   = 8'hC3;
  localparam logic [7:0]  CONFIRM = 8'h3C;
  localparam logic [15:0] SEED    = 16'h5A3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   cfg_o, data_o;
  logic [AW-1:0] addr_o;
  logic          valid_o, ready_o;

  int checks = 0, errors = 0;
  logic [15:0] cur_cfg;

  always #4 clk_i = ~clk_i;

  burst_read_seq dut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns beat index, -1 no data, -2 wait cycle
  function automatic int exp_beat(input int c, input logic [AW-1:0] s, input logic [15:0] cfg);
    int x, d, pre;
    bit cont;
    x    = (cfg[13:11] < 2) ? 2 : int'(cfg[13:11]);
    cont = !(cfg[2:0] == 3'b001 || cfg[2:0] == 3'b010);
    d    = c - x;
    if (d < 0) return -1;
    if (!cont) return (d < ((cfg[2:0] == 3'b010) ? 8 : 4)) ? d : -1;
    if (s[1:0] == 2'b00) return d;
    pre = 4 - int'(s[1:0]);
    if (d < pre)  return d;
    if (d == pre) return -2;
    return d - 1;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int k, input logic [AW-1:0] s, input logic [15:0] cfg);
    logic [AW-1:0] m, lo, kk;
    kk = AW'(k);
    if (!(cfg[2:0] == 3'b001 || cfg[2:0] == 3'b010)) return s + kk;
    m  = (cfg[2:0] == 3'b010) ? AW'(7) : AW'(3);
    lo = cfg[7] ? (s ^ kk) : (s + kk);
    return (s & ~m) | (lo & m);
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk_i); wr_i = 1; wr_data_i = SETUP; addr_i = AW'($urandom);
    @(negedge clk_i); wr_data_i = CONFIRM; addr_i = {5'($urandom), v};
    @(negedge clk_i); wr_i = 0;
    cur_cfg = v;
    check(cfg_o == v, "R1", cfg_o, v);
  endtask

  task automatic run_burst(input logic [AW-1:0] s, input int ncyc, input bit do_stop);
    bit cont;
    cont = !(cur_cfg[2:0] == 3'b001 || cur_cfg[2:0] == 3'b010);
    @(negedge clk_i); start_i = 1; addr_i = s;
    for (int c = 1; c <= ncyc; c++) begin
      int k;
      logic [AW-1:0] ea;
      @(negedge clk_i); start_i = 0;
      k = exp_beat(c, s, cur_cfg);
      check(valid_o == (k >= 0), (k == -2) ? "R10" : "R5", valid_o, k >= 0);
      check(ready_o == (cont ? (k >= 0) : 1'b1), (k == -2) ? "R10" : "R11", ready_o, cont ? (k >= 0) : 1);
      if (k >= 0) begin
        ea = exp_addr(k, s, cur_cfg);
        check(addr_o == ea, cont ? "R9" : (cur_cfg[7] ? "R8" : "R7"), addr_o, ea);
        check(data_o == (ea[15:0] ^ SEED), "R13", data_o, ea[15:0] ^ SEED);
      end
    end
    if (do_stop) begin
      stop_i = 1;
      @(negedge clk_i); stop_i = 0;
      check(!valid_o && ready_o, "R12", {valid_o, ready_o}, 2'b01);
    end
  endtask

  function automatic int span(input logic [15:0] cfg);
    int x;
    x = (cfg[13:11] < 2) ? 2 : int'(cfg[13:11]);
    if (cfg[2:0] == 3'b001) return x + 4 + 2;
    if (cfg[2:0] == 3'b010) return x + 8 + 2;
    return x + 10;
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R3 reset state
    check(cfg_o == 16'h8000, "R3", cfg_o, 16'h8000);
    check(!valid_o && ready_o, "R3", {valid_o, ready_o}, 2'b01);
    cur_cfg = 16'h8000;

    // R4 start ignored in asynchronous mode
    @(negedge clk_i); start_i = 1; addr_i = AW'(5);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i); start_i = 0;
      check(!valid_o && ready_o, "R4", {valid_o, ready_o}, 2'b01);
    end

    // R2 wrong confirm and lone confirm
    @(negedge clk_i); wr_i = 1; wr_data_i = SETUP;
    @(negedge clk_i); wr_data_i = 8'h55; addr_i = AW'(16'h1234);
    @(negedge clk_i); wr_data_i = CONFIRM; addr_i = AW'(16'h4321);
    @(negedge clk_i); wr_i = 0;
    check(cfg_o == 16'h8000, "R2", cfg_o, 16'h8000);

    // R7 sequential 4, start offset 2, latency 3
    write_cfg({2'b00, 3'd3, 3'b000, 1'b0, 1'b1, 3'b000, 3'b001});
    run_burst(AW'('h00102), span(cur_cfg), 1'b1);
    // R8 interleaved 4, offsets 1 and 3
    write_cfg({2'b00, 3'd2, 3'b000, 1'b1, 1'b1, 3'b000, 3'b001});
    run_burst(AW'('h0A0F1), span(cur_cfg), 1'b1);
    run_burst(AW'('h0A0F3), span(cur_cfg), 1'b1);
    // R6 length 8 interleaved, latency code 0 acts as 2
    write_cfg({2'b00, 3'd0, 3'b000, 1'b1, 1'b1, 3'b000, 3'b010});
    run_burst(AW'('h1235D), span(cur_cfg), 1'b1);
    // R9 R10 open-ended: aligned, offsets 1..3, top-of-array wrap
    write_cfg({2'b00, 3'd4, 3'b000, 1'b1, 1'b1, 3'b000, 3'b111});
    run_burst(AW'('h00400), 14, 1'b1);
    run_burst(AW'('h00401), 14, 1'b1);
    run_burst(AW'('h00402), 14, 1'b1);
    run_burst(AW'('h00403), 14, 1'b1);
    run_burst(AW'('h1FFFFD), 14, 1'b1);
    // R12 restart mid-burst
    write_cfg({2'b00, 3'd2, 3'b000, 1'b0, 1'b1, 3'b000, 3'b010});
    run_burst(AW'('h00770), 5, 1'b0);
    run_burst(AW'('h00E05), span(cur_cfg), 1'b1);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [15:0] v;
      logic [2:0]  lc;
      case ($urandom % 5)
        0: lc = 3'b001;
        1: lc = 3'b010;
        2: lc = 3'b111;
        3: lc = 3'b011;
        default: lc = 3'b000;
      endcase
      v = {1'b0, 1'b0, 3'($urandom), 3'($urandom), 1'($urandom), 1'b1, 3'($urandom), lc};
      write_cfg(v);
      run_burst(AW'($urandom), span(v), 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule